// File: doc/BRIEF.md
# Multicycle Register-Transfer Processor Core

This block is a small 32-bit processor core. A single sequencer steps it through fetch, decode, operand access and write-back, one register transfer at a time. Every memory access goes through one byte-addressed port, and each read or write on that port lasts a fixed number of clock cycles. The default is two cycles. For the whole access the core holds the address, the write data and the strobe unchanged. The register bank has sixteen 32-bit entries. Entry 0 is hard-wired to zero.

The core runs five instructions:

- a load through a register pointer;
- a store to a base register plus a signed 16-bit offset;
- a register/memory swap;
- a register-plus-memory add;
- a memory-to-memory add whose two operands are both addressed through registers.

The swap and the register-plus-memory add are two words long. Their second word is a full 32-bit address, fetched in its own memory step. Any other opcode stops the core. Once stopped, it raises a flag and makes no further memory accesses until reset.

The first word of each instruction has four fields:

| Bits | Field |
|------|-------|
| 31:24 | opcode |
| 23:20 | register field X |
| 19:16 | register field Y |
| 15:0 | signed offset |

Top module: `mcyc_core`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the core drives a read of address 0 with the write strobe low and the halt flag low. Reset clears the program counter and all registers to zero.
- R2: Every read and every write lasts exactly MEM_CYCLES consecutive cycles (default 2). During that time the address, the write data (for writes) and the strobe stay constant. Read and write strobes are never high together.
- R3: Each fetch reads the word at the program counter and then advances the counter by 4. The two-word opcodes (0x03 and 0x04) perform a second fetch at the advanced counter and advance it by 4 again. Each instruction's reads follow in program order.
- R4: Register 0 reads as zero. A write aimed at it (for example, a load with X=0) leaves it at zero.
- R5: Opcode 0x01 (load) reads the word at the address held in register Y and writes it into register X.
- R6: Opcode 0x02 (store) writes register X to the address formed by adding register Y to the sign-extended offset in bits 15:0. Negative offsets are included.
- R7: Opcode 0x03 (swap) reads the word at the address given in the second word. It then writes register X's old value to that address, and only after that puts the old memory word into register X.
- R8: Opcode 0x04 (add from memory) reads the word at the address given in the second word and writes register X plus that word into register X. Memory is not written.
- R9: Opcode 0x05 (memory add) reads the word at register X's address, then the word at register Y's address. It writes their sum to register X's address, including when X and Y are the same register.
- R10: Any other opcode, 0x00 and 0xFF included, sets the halt flag. The flag stays set until reset. While it is set, neither strobe is ever raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_wdata | output | 32 | Data for a memory write |
| mem_rdata | input | 32 | Data returned by memory, sampled at the end of the last read cycle |
| mem_rd | output | 1 | Read strobe, held for the whole access |
| mem_wr | output | 1 | Write strobe, held for the whole access |
| halted | output | 1 | Sticky flag showing that an undefined opcode was decoded |

## Verification
The test program runs every instruction class against a byte-addressed memory model, and a scoreboard predicts each access address and each written value in order.

Some cases are chosen to tell one kind of fault apart from another:
- A store with a negative offset separates sign extension from zero extension.
- A swap followed by a store of the same register shows whether the old memory word or the old register value ended up in the register.
- A memory add whose two operands are the same register exposes operand latching that reuses a stale pointer.
- A load into register 0, followed by a store of register 0, exposes a write that leaked into the zero register.

The program ends on an undefined opcode. This checks that the core halts and leaves the memory port quiet afterwards.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   typedef enum logic [2:0] {
      S_FETCH  = 3'd0,
      S_DECODE = 3'd1,
      S_FETCH2 = 3'd2,
      S_OPRD   = 3'd3,
      S_OPRD2  = 3'd4,
      S_OPWR   = 3'd5,
      S_HALT   = 3'd6
   } mc_state_e;

   localparam logic [7:0] OP_LOAD  = 8'h01;
   localparam logic [7:0] OP_STORE = 8'h02;
   localparam logic [7:0] OP_SWAP  = 8'h03;
   localparam logic [7:0] OP_ADDM  = 8'h04;
   localparam logic [7:0] OP_ADDMM = 8'h05;

endpackage

// File: rtl/mcyc_adder.sv
module mcyc_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   output logic [W-1:0] y_o
);
   if (W < 1) begin : g_bad_w
      $error("mcyc_adder: W must be positive");
   end

   assign y_o = a_i + b_i;
endmodule

// File: rtl/mcyc_regfile.sv
module mcyc_regfile #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   localparam int AW    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rx_addr,
   input  logic [AW-1:0]     ry_addr,
   output logic [DATA_W-1:0] rx_data,
   output logic [DATA_W-1:0] ry_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   if (NREGS < 2 || NREGS > 16 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_n
      $error("mcyc_regfile: NREGS must be a power of two from 2 to 16");
   end

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign regs[i] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_addr == AW'(i))
               q <= wr_data;
         end
         assign regs[i] = q;
      end
   end

   assign rx_data = regs[rx_addr];
   assign ry_data = regs[ry_addr];

   // R4: the zero entry never returns a nonzero value, even after a write to it
   p_zero_reg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == '0) |=> (rx_addr != '0 || rx_data == '0));
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
   import mcyc_pkg::*;
#(
   parameter int MEM_CYCLES = 2,
   localparam int CW        = (MEM_CYCLES > 1) ? $clog2(MEM_CYCLES) : 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] opcode,
   output mc_state_e  state_o,
   output logic       step_done,
   output logic       halted
);
   if (MEM_CYCLES < 1) begin : g_bad_mc
      $error("mcyc_seq: MEM_CYCLES must be at least 1");
   end

   mc_state_e state_q, state_d;
   logic [CW-1:0] cnt_q;
   logic in_mem;

   assign in_mem    = state_q inside {S_FETCH, S_FETCH2, S_OPRD, S_OPRD2, S_OPWR};
   assign step_done = in_mem && (cnt_q == CW'(MEM_CYCLES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (step_done)
         cnt_q <= '0;
      else if (in_mem)
         cnt_q <= cnt_q + CW'(1);
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_FETCH:  if (step_done) state_d = S_DECODE;
         S_DECODE: begin
            case (opcode)
               OP_LOAD, OP_ADDMM: state_d = S_OPRD;
               OP_STORE:          state_d = S_OPWR;
               OP_SWAP, OP_ADDM:  state_d = S_FETCH2;
               default:           state_d = S_HALT;
            endcase
         end
         S_FETCH2: if (step_done) state_d = S_OPRD;
         S_OPRD: begin
            if (step_done) begin
               if (opcode == OP_ADDMM)     state_d = S_OPRD2;
               else if (opcode == OP_SWAP) state_d = S_OPWR;
               else                        state_d = S_FETCH;
            end
         end
         S_OPRD2:  if (step_done) state_d = S_OPWR;
         S_OPWR:   if (step_done) state_d = S_FETCH;
         S_HALT:   state_d = S_HALT;
         default:  state_d = S_HALT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= S_FETCH;
      else
         state_q <= state_d;
   end

   assign state_o = state_q;
   assign halted  = (state_q == S_HALT);

   // R10: once stopped, the sequencer stays stopped
   p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> halted);
   // R3: decode lasts a single cycle
   p_decode_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DECODE) |=> (state_q != S_DECODE));
endmodule

// File: rtl/mcyc_core.sv
module mcyc_core
   import mcyc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREGS      = 16,
   parameter int MEM_CYCLES = 2,
   localparam int AW        = $clog2(NREGS),
   localparam int DISP_W    = 16,
   localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              halted
);
   if (DATA_W != 32) begin : g_bad_dw
      $error("mcyc_core: the instruction layout needs DATA_W of 32");
   end

   mc_state_e state;
   logic      step_done;

   logic [DATA_W-1:0] pc_q, ir_q, mar_q, mdr_q, tmp_q;
   logic [7:0]        opcode;
   logic [AW-1:0]     fx, fy;
   logic [DATA_W-1:0] disp_x;
   logic [DATA_W-1:0] rx_data, ry_data;
   logic [DATA_W-1:0] add_a, add_b, add_y;
   logic              rf_we;
   logic [DATA_W-1:0] rf_wd;

   assign opcode = ir_q[31:24];
   assign fx     = ir_q[20 +: AW];
   assign fy     = ir_q[16 +: AW];
   assign disp_x = {{(DATA_W - DISP_W){ir_q[DISP_W-1]}}, ir_q[DISP_W-1:0]};

   mcyc_seq #(.MEM_CYCLES(MEM_CYCLES)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .opcode    (opcode),
      .state_o   (state),
      .step_done (step_done),
      .halted    (halted)
   );

   mcyc_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .rx_addr (fx),
      .ry_addr (fy),
      .rx_data (rx_data),
      .ry_data (ry_data),
      .wr_en   (rf_we),
      .wr_addr (fx),
      .wr_data (rf_wd)
   );

   // one shared adder, operands chosen by the current step
   always_comb begin
      case (state)
         S_FETCH, S_FETCH2: begin add_a = pc_q;    add_b = PC_STEP;   end
         S_DECODE:          begin add_a = ry_data; add_b = disp_x;    end
         S_OPRD:            begin add_a = rx_data; add_b = mem_rdata; end
         S_OPRD2:           begin add_a = tmp_q;   add_b = mem_rdata; end
         default:           begin add_a = '0;      add_b = '0;        end
      endcase
   end

   mcyc_adder #(.W(DATA_W)) u_add (
      .a_i (add_a),
      .b_i (add_b),
      .y_o (add_y)
   );

   // memory port, driven only from registered state
   assign mem_addr  = (state == S_FETCH || state == S_FETCH2) ? pc_q : mar_q;
   assign mem_rd    = state inside {S_FETCH, S_FETCH2, S_OPRD, S_OPRD2};
   assign mem_wr    = (state == S_OPWR);
   assign mem_wdata = mdr_q;

   // register write-back
   always_comb begin
      rf_we = 1'b0;
      rf_wd = mem_rdata;
      if (step_done && state == S_OPRD && (opcode == OP_LOAD || opcode == OP_ADDM)) begin
         rf_we = 1'b1;
         rf_wd = (opcode == OP_ADDM) ? add_y : mem_rdata;
      end else if (step_done && state == S_OPWR && opcode == OP_SWAP) begin
         rf_we = 1'b1;
         rf_wd = tmp_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         ir_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         tmp_q <= '0;
      end else begin
         case (state)
            S_FETCH: if (step_done) begin
               ir_q <= mem_rdata;
               pc_q <= add_y;
            end
            S_DECODE: begin
               case (opcode)
                  OP_LOAD:  mar_q <= ry_data;
                  OP_STORE: begin mar_q <= add_y; mdr_q <= rx_data; end
                  OP_ADDMM: mar_q <= rx_data;
                  default:  ;
               endcase
            end
            S_FETCH2: if (step_done) begin
               mar_q <= mem_rdata;
               pc_q  <= add_y;
            end
            S_OPRD: if (step_done) begin
               tmp_q <= mem_rdata;
               if (opcode == OP_SWAP)  mdr_q <= rx_data;
               if (opcode == OP_ADDMM) mar_q <= ry_data;
            end
            S_OPRD2: if (step_done) begin
               mdr_q <= add_y;
               mar_q <= rx_data;
            end
            default: ;
         endcase
      end
   end

   // R2: an unfinished read keeps its strobe and address
   p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !step_done) |=> (mem_rd && $stable(mem_addr)));
   // R2: an unfinished write keeps strobe, address and data
   p_wr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !step_done) |=> (mem_wr && $stable(mem_addr) && $stable(mem_wdata)));
   // R2: never read and write at once
   p_rd_wr_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   // R10: a stopped core leaves the port idle
   p_halt_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> (!mem_rd && !mem_wr));
   // R3: a completed fetch advances the program counter by one word
   p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_FETCH && step_done) |=> (pc_q == $past(pc_q) + PC_STEP));
endmodule

// File: tb/mcyc_core_bench.sv
module mcyc_core_bench;
   logic        clk;
   logic        rst_n;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_rd, mem_wr, halted;

   logic [31:0] mem [0:63];

   int checks = 0;
   int fails  = 0;

   logic [31:0] rd_q [$];
   string       rd_tag_q [$];
   logic [31:0] wa_q [$];
   logic [31:0] wd_q [$];
   string       wr_tag_q [$];

   initial clk = 1'b0;
   always #10 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:2]];

   mcyc_core u_mcyc_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .halted    (halted)
   );

   function automatic logic [31:0] enc(input logic [7:0] op, input logic [3:0] x,
                                       input logic [3:0] y, input logic [15:0] d);
      return {op, x, y, d};
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic push_rd(input logic [31:0] a, input string tag);
      rd_q.push_back(a);
      rd_tag_q.push_back(tag);
   endtask

   task automatic push_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
      wa_q.push_back(a);
      wd_q.push_back(d);
      wr_tag_q.push_back(tag);
   endtask

   // monitor: samples once per cycle between rising edges
   task automatic monitor();
      int rd_run = 0;
      int wr_run = 0;
      logic [31:0] rd_a = '0;
      logic [31:0] wr_a = '0;
      logic [31:0] wr_d = '0;
      forever begin
         if (mem_rd && mem_wr)
            check(1'b0, "R2 strobes overlap", 32'd1, 32'd0);
         if (mem_rd) begin
            if (rd_run == 0) rd_a = mem_addr;
            else check(mem_addr == rd_a, "R2 read address held", mem_addr, rd_a);
            rd_run++;
            if (rd_run == 2) begin
               if (rd_q.size() == 0)
                  check(1'b0, "R3 unexpected read", mem_addr, 32'hFFFF_FFFF);
               else begin
                  logic [31:0] e;
                  string t;
                  e = rd_q.pop_front();
                  t = rd_tag_q.pop_front();
                  check(mem_addr == e, t, mem_addr, e);
               end
               rd_run = 0;
            end
         end else if (rd_run != 0) begin
            check(1'b0, "R2 read too short", 32'(rd_run), 32'd2);
            rd_run = 0;
         end
         if (mem_wr) begin
            if (wr_run == 0) begin wr_a = mem_addr; wr_d = mem_wdata; end
            else begin
               check(mem_addr == wr_a, "R2 write address held", mem_addr, wr_a);
               check(mem_wdata == wr_d, "R2 write data held", mem_wdata, wr_d);
            end
            wr_run++;
            if (wr_run == 2) begin
               if (wa_q.size() == 0)
                  check(1'b0, "R6 unexpected write", mem_addr, 32'hFFFF_FFFF);
               else begin
                  logic [31:0] ea, ed;
                  string t;
                  ea = wa_q.pop_front();
                  ed = wd_q.pop_front();
                  t  = wr_tag_q.pop_front();
                  check(mem_addr == ea, {t, " address"}, mem_addr, ea);
                  check(mem_wdata == ed, {t, " data"}, mem_wdata, ed);
               end
               mem[mem_addr[7:2]] = mem_wdata;
               wr_run = 0;
            end
         end else if (wr_run != 0) begin
            check(1'b0, "R2 write too short", 32'(wr_run), 32'd2);
            wr_run = 0;
         end
         @(negedge clk);
      end
   endtask

   initial begin
      bit done;
      for (int i = 0; i < 64; i++) mem[i] = '0;
      // program
      mem[0]  = enc(8'h04, 4'd1, 4'd0, 16'h0000); mem[1]  = 32'h80;  // r1 += [0x80]
      mem[2]  = enc(8'h04, 4'd2, 4'd0, 16'h0000); mem[3]  = 32'h84;  // r2 += [0x84]
      mem[4]  = enc(8'h01, 4'd3, 4'd2, 16'h0000);                    // r3 = [r2]
      mem[5]  = enc(8'h02, 4'd3, 4'd2, 16'h0020);                    // [r2+0x20] = r3
      mem[6]  = enc(8'h03, 4'd1, 4'd0, 16'h0000); mem[7]  = 32'h88;  // swap r1,[0x88]
      mem[8]  = enc(8'h02, 4'd1, 4'd2, 16'hFFFC);                    // [r2-4] = r1
      mem[9]  = enc(8'h04, 4'd4, 4'd0, 16'h0000); mem[10] = 32'h8C;  // r4 += [0x8C]
      mem[11] = enc(8'h05, 4'd2, 4'd4, 16'h0000);                    // [r2] = [r2]+[r4]
      mem[12] = enc(8'h01, 4'd0, 4'd2, 16'h0000);                    // r0 = [r2]
      mem[13] = enc(8'h02, 4'd0, 4'd2, 16'h0024);                    // [r2+0x24] = r0
      mem[14] = enc(8'h05, 4'd4, 4'd4, 16'h0000);                    // [r4] = [r4]+[r4]
      mem[15] = 32'hFF00_0000;                                       // undefined
      // data
      mem[32] = 32'd100;
      mem[33] = 32'h80;
      mem[34] = 32'hDEAD_BEEF;
      mem[35] = 32'h90;
      mem[36] = 32'd5;

      // expected accesses, in program order
      push_rd(32'h00, "R3 fetch add@0");   push_rd(32'h04, "R3 fetch2 add@0");
      push_rd(32'h80, "R8 operand");
      push_rd(32'h08, "R3 fetch add@8");   push_rd(32'h0C, "R3 fetch2 add@8");
      push_rd(32'h84, "R8 operand");
      push_rd(32'h10, "R3 fetch load");    push_rd(32'h80, "R5 load pointer");
      push_rd(32'h14, "R3 fetch store");
      push_wr(32'hA0, 32'd100, "R5 R6 store of loaded value");
      push_rd(32'h18, "R3 fetch swap");    push_rd(32'h1C, "R3 fetch2 swap");
      push_rd(32'h88, "R7 swap read");
      push_wr(32'h88, 32'd100, "R7 swap writes old register");
      push_rd(32'h20, "R3 fetch store");
      push_wr(32'h7C, 32'hDEAD_BEEF, "R6 R7 negative offset, swapped register");
      push_rd(32'h24, "R3 fetch add@24");  push_rd(32'h28, "R3 fetch2 add@24");
      push_rd(32'h8C, "R8 operand");
      push_rd(32'h2C, "R3 fetch madd");    push_rd(32'h80, "R9 first operand");
      push_rd(32'h90, "R9 second operand");
      push_wr(32'h80, 32'd105, "R9 sum to first pointer");
      push_rd(32'h30, "R3 fetch load r0"); push_rd(32'h80, "R5 load pointer");
      push_rd(32'h34, "R3 fetch store r0");
      push_wr(32'hA4, 32'd0, "R4 zero register stays zero");
      push_rd(32'h38, "R3 fetch madd same"); push_rd(32'h90, "R9 same reg first");
      push_rd(32'h90, "R9 same reg second");
      push_wr(32'h90, 32'd10, "R9 same register doubled");
      push_rd(32'h3C, "R3 fetch undefined");

      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      check(mem_rd == 1'b1, "R1 read during reset", 32'(mem_rd), 32'd1);
      check(mem_addr == 32'h0, "R1 address during reset", mem_addr, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(mem_rd == 1'b1 && mem_wr == 1'b0, "R1 first fetch strobes",
            {30'd0, mem_wr, mem_rd}, 32'd1);
      check(mem_addr == 32'h0, "R1 first fetch address", mem_addr, 32'h0);
      check(halted == 1'b0, "R1 halt flag clear", 32'(halted), 32'd0);
      fork monitor(); join_none

      done = 1'b0;
      for (int c = 0; c < 5000 && !done; c++) begin
         @(negedge clk);
         #2;
         if (halted) done = 1'b1;
      end
      if (!done) begin
         check(1'b0, "R10 watchdog expired", 32'd0, 32'd1);
      end else begin
         for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            #2;
            check(halted && !mem_rd && !mem_wr, "R10 halted and idle",
                  {29'd0, halted, mem_wr, mem_rd}, 32'd4);
         end
      end
      check(rd_q.size() == 0, "R3 all expected reads seen", 32'(rd_q.size()), 32'd0);
      check(wa_q.size() == 0, "R6 all expected writes seen", 32'(wa_q.size()), 32'd0);
      check(mem[32] == 32'd105, "R9 final memory sum", mem[32], 32'd105);
      check(mem[34] == 32'd100, "R7 final swapped word", mem[34], 32'd100);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule